// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a 16-bit segment selector and a 32-bit offset into a 32-bit linear address. It uses descriptor tables that live in ordinary memory. The selector is split into a descriptor index, a table-choice bit and a requested privilege level. The table-choice bit picks the base of either the global table or the local table, and the descriptor address is that base plus eight times the index.

The block then fetches the 64-bit descriptor as two 32-bit words through a synchronous read port. It checks the descriptor's present bit, its privilege level and its limit. If every check passes, it returns the descriptor base plus the offset. If any check fails, it raises a fault instead.

The block serves one request at a time. A request is taken when `req_valid` is high and `busy` is low. The answer appears as a one-cycle `done` pulse, with `fault` and `lin_addr` valid in that same cycle.

Top module: `seg_xlat_top`

## Requirements
- R1: The selector is split as index = bits 15:3, table choice = bit 2 and requested level = bits 1:0. Table choice 0 selects `glb_tbl_base` and table choice 1 selects `loc_tbl_base`. The first read address is the selected base plus index times 8.
- R2: A non-null request issues exactly two reads on consecutive cycles: first the descriptor address, then that address plus 4. Read data is expected one cycle after `mem_rd_en`.
- R3: Descriptor layout. The first word is the 32-bit base. In the second word, bits 19:0 are the limit, bits 21:20 are the descriptor privilege level and bit 23 is the present bit. All other bits of the second word are ignored.
- R4: When no fault is raised, `lin_addr` equals base plus offset, modulo 2^32.
- R5: A null selector (index 0 with table choice 0) faults, and no memory read is issued for it.
- R6: A descriptor whose present bit is 0 faults.
- R7: The request faults when the numeric maximum of the current level and the requested level is greater than the descriptor level.
- R8: The request faults when the offset is greater than the zero-extended limit. An offset equal to the limit is allowed.
- R9: `fault` is high only while `done` is high, and `lin_addr` is 0 whenever `fault` is high.
- R10: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` stays high for the whole fetch. Requests and input changes made while `busy` is high have no effect. All outputs are 0 after reset.
- R11: For a non-null request, `done` is high in the fourth cycle after the accepting edge. For a null request, `done` is high in the first cycle after the accepting edge. `done` lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Segment selector |
| req_offset | input | 32 | Offset inside the segment |
| req_cpl | input | 2 | Current privilege level of the requester |
| glb_tbl_base | input | 32 | Base address of the global descriptor table |
| loc_tbl_base | input | 32 | Base address of the local descriptor table |
| busy | output | 1 | High while a descriptor fetch is in flight |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the enable |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Translation refused (valid with done) |
| lin_addr | output | 32 | Linear address (valid with done) |

## Verification
The completion of one translation and the acceptance of the next can fall in the same cycle. In that cycle `done` is high and `busy` is already low, so a request that is being held is taken at once.

The bench keeps `req_valid` high throughout and presents the next selector in exactly the cycle in which `done` shows. While `busy` is high, it drives unrelated selectors and offsets onto the inputs.

Each result is judged against an expected value computed from the table model. The bench also checks the latency from acceptance to `done` for both the null and the fetching paths, and the count and addresses of the reads. Together these show that neither a held request nor the mid-fetch input noise leaks into a neighbouring translation.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    parameter int ADDR_W     = 32;
    parameter int WORD_W     = 32;
    parameter int SEL_W      = 16;
    parameter int PRIV_W     = 2;
    parameter int IDX_W      = SEL_W - 1 - PRIV_W;
    parameter int DESC_SHIFT = 3;
    parameter int WORD_STEP  = WORD_W / 8;
    parameter int LIMIT_W    = 20;
    // field positions inside the second descriptor word
    parameter int LIM_LSB    = 0;
    parameter int DPL_LSB    = 20;
    parameter int PRES_BIT   = 23;

    typedef struct packed {
        logic [IDX_W-1:0]  index;
        logic              use_local;
        logic [PRIV_W-1:0] rpl;
    } selector_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
        logic [PRIV_W-1:0]  dpl;
        logic               present;
    } seg_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_LAST
    } fetch_state_t;

    typedef enum logic [2:0] {
        FK_NONE,
        FK_NULL,
        FK_ABSENT,
        FK_PRIV,
        FK_LIMIT
    } fault_kind_t;

    function automatic seg_desc_t unpack_desc(input logic [WORD_W-1:0] lo,
                                              input logic [WORD_W-1:0] hi);
        seg_desc_t d;
        d.base    = ADDR_W'(lo);
        d.limit   = hi[LIM_LSB +: LIMIT_W];
        d.dpl     = hi[DPL_LSB +: PRIV_W];
        d.present = hi[PRES_BIT];
        return d;
    endfunction

    function automatic logic [PRIV_W-1:0] weaker_priv(input logic [PRIV_W-1:0] a,
                                                      input logic [PRIV_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_null_sel(input selector_t s);
        return (s.index == '0) && !s.use_local;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlat_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_raw,
    input  logic [ADDR_W-1:0] gbl_base,
    input  logic [ADDR_W-1:0] loc_base,
    output selector_t         sel,
    output logic              null_sel,
    output logic [ADDR_W-1:0] desc_addr
);
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] idx_off;

    assign sel       = selector_t'(sel_raw);
    assign null_sel  = is_null_sel(sel);
    assign tbl_base  = sel.use_local ? loc_base : gbl_base;
    assign idx_off   = ADDR_W'(sel.index) << DESC_SHIFT;
    assign desc_addr = tbl_base + idx_off;

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_xlat_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] rpl,
    input  logic [ADDR_W-1:0] offset,
    output fault_kind_t       kind,
    output logic [ADDR_W-1:0] lin
);
    logic [PRIV_W-1:0] eff_priv;
    logic              over_limit;

    assign eff_priv   = weaker_priv(cpl, rpl);
    assign over_limit = offset > ADDR_W'(desc.limit);

    always_comb begin
        if (!desc.present)
            kind = FK_ABSENT;
        else if (eff_priv > desc.dpl)
            kind = FK_PRIV;
        else if (over_limit)
            kind = FK_LIMIT;
        else
            kind = FK_NONE;
    end

    assign lin = (kind == FK_NONE) ? desc.base + offset : '0;

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_null,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              busy,
    output logic              accept,
    output logic              eval,
    output logic [WORD_W-1:0] word_lo
);
    fetch_state_t      st;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] lo_q;

    assign accept = req_valid && (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            addr_q <= '0;
            lo_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q <= req_addr;
                        if (!req_null)
                            st <= ST_RD_LO;
                    end
                end
                ST_RD_LO: st <= ST_RD_HI;
                ST_RD_HI: begin
                    lo_q <= mem_rd_data;
                    st   <= ST_LAST;
                end
                ST_LAST: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en   = (st == ST_RD_LO) || (st == ST_RD_HI);
    assign mem_rd_addr = (st == ST_RD_HI) ? addr_q + ADDR_W'(WORD_STEP) : addr_q;
    assign busy        = (st != ST_IDLE);
    assign eval        = (st == ST_LAST);
    assign word_lo     = lo_q;

    // R2: second read follows the first at the next word
    assert_read_pair_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_en) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(WORD_STEP)));

    // R2: evaluation only after two read cycles
    assert_eval_after_reads_R2: assert property (@(posedge clk) disable iff (rst)
        eval |-> ($past(mem_rd_en) && !$past(accept)));

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [PRIV_W-1:0] req_cpl,
    input  logic [ADDR_W-1:0] glb_tbl_base,
    input  logic [ADDR_W-1:0] loc_tbl_base,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] lin_addr
);
    selector_t         sel;
    logic              req_null;
    logic [ADDR_W-1:0] desc_addr;
    logic              accept;
    logic              eval;
    logic [WORD_W-1:0] word_lo;
    seg_desc_t         desc;
    fault_kind_t       kind;
    logic [ADDR_W-1:0] chk_lin;

    logic [ADDR_W-1:0] offset_q;
    logic [PRIV_W-1:0] cpl_q;
    logic [PRIV_W-1:0] rpl_q;
    logic              done_q;
    logic              fault_q;
    logic [ADDR_W-1:0] lin_q;
    logic              unused_desc_bits;

    seg_sel_decode u_dec (
        .sel_raw   (req_sel),
        .gbl_base  (glb_tbl_base),
        .loc_base  (loc_tbl_base),
        .sel       (sel),
        .null_sel  (req_null),
        .desc_addr (desc_addr)
    );

    seg_fetch_ctrl u_fetch (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_null    (req_null),
        .req_addr    (desc_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .busy        (busy),
        .accept      (accept),
        .eval        (eval),
        .word_lo     (word_lo)
    );

    assign desc = unpack_desc(word_lo, mem_rd_data);
    assign unused_desc_bits = ^{mem_rd_data[WORD_W-1:PRES_BIT+1],
                                mem_rd_data[PRES_BIT-1:DPL_LSB+PRIV_W]};

    seg_access_check u_chk (
        .desc   (desc),
        .cpl    (cpl_q),
        .rpl    (rpl_q),
        .offset (offset_q),
        .kind   (kind),
        .lin    (chk_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            cpl_q    <= '0;
            rpl_q    <= '0;
        end else if (accept) begin
            offset_q <= req_offset;
            cpl_q    <= req_cpl;
            rpl_q    <= sel.rpl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            lin_q   <= '0;
        end else if (accept && req_null) begin
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            lin_q   <= '0;
        end else if (eval) begin
            done_q  <= 1'b1;
            fault_q <= (kind != FK_NONE);
            lin_q   <= chk_lin;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end
    end

    assign done     = done_q;
    assign fault    = fault_q;
    assign lin_addr = lin_q;

    assert_fault_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (lin_addr == '0));

    assert_null_no_read_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && req_null) |=> (!mem_rd_en && done && fault));

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_null) |=> busy);

endmodule

// File: tb/sim_seg_xlat_top.sv
`timescale 1ns/1ps
module sim_seg_xlat_top;

    localparam logic [31:0] GB = 32'h0001_0000;
    localparam logic [31:0] LB = 32'h0020_0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_cpl = '0;
    logic        busy, mem_rd_en, done, fault;
    logic [31:0] mem_rd_addr, lin_addr;
    logic [31:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seg_xlat_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_offset(req_offset), .req_cpl(req_cpl),
        .glb_tbl_base(GB), .loc_tbl_base(LB),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .done(done), .fault(fault), .lin_addr(lin_addr)
    );

    // table model: descriptor contents derived from the descriptor address
    function automatic logic [31:0] d_base(input logic [31:0] d);
        return ~(d << 2);
    endfunction
    function automatic logic [19:0] d_lim(input logic [31:0] d);
        return {d[10:3], 12'h7FF};
    endfunction
    function automatic logic [1:0] d_dpl(input logic [31:0] d);
        return d[4:3];
    endfunction
    function automatic logic d_pres(input logic [31:0] d);
        return d[6:3] != 4'd5;
    endfunction
    function automatic logic [31:0] model_word(input logic [31:0] a);
        logic [31:0] d;
        d = {a[31:3], 3'b000};
        if (!a[2]) return d_base(d);
        return {d[10:3], d_pres(d), 1'b1, d_dpl(d), d_lim(d)};
    endfunction
    function automatic logic [31:0] sel_daddr(input logic [15:0] s);
        return (s[2] ? LB : GB) + {16'h0, s[15:3], 3'b000};
    endfunction

    always @(posedge clk) mem_rd_data <= mem_rd_en ? model_word(mem_rd_addr) : 32'h0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge with busy low; returns at the falling edge where done shows
    task automatic run_req(input logic [15:0] s, input logic [31:0] off, input logic [1:0] cpl);
        logic [31:0] da, base, el;
        logic [1:0]  eff;
        logic        nul, pres, priv_bad, over, ef;
        logic [31:0] ra [0:3];
        int lat, nreads;
        string ftag;
        da       = sel_daddr(s);
        nul      = (s[15:3] == 13'd0) && !s[2];
        base     = d_base(da);
        pres     = d_pres(da);
        eff      = (cpl > s[1:0]) ? cpl : s[1:0];
        priv_bad = eff > d_dpl(da);
        over     = off > {12'h0, d_lim(da)};
        ef       = nul || !pres || priv_bad || over;
        el       = ef ? 32'h0 : base + off;
        ftag     = nul ? "R5" : !pres ? "R6" : priv_bad ? "R7" : over ? "R8" : "R3";

        req_valid  = 1'b1;
        req_sel    = s;
        req_offset = off;
        req_cpl    = cpl;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        nreads = 0;
        while (!done && lat < 10) begin
            chk(busy == 1'b1, "R10 busy during fetch", {31'h0, busy}, 32'h1);
            if (mem_rd_en && nreads < 4) begin
                ra[nreads] = mem_rd_addr;
                nreads++;
            end
            // noise on the inputs while busy must be ignored (R10)
            req_sel    = ~s ^ 16'h0004;
            req_offset = off ^ 32'hA5A5_5A5A;
            req_cpl    = ~cpl;
            @(negedge clk);
            lat++;
        end
        chk(lat == (nul ? 1 : 4), "R11 latency", lat, nul ? 1 : 4);
        chk(fault == ef, ftag, {31'h0, fault}, {31'h0, ef});
        chk(lin_addr == el, ef ? "R9 zero address" : "R4 linear address", lin_addr, el);
        chk(nreads == (nul ? 0 : 2), nul ? "R5 read count" : "R2 read count", nreads, nul ? 0 : 2);
        if (!nul && nreads == 2) begin
            chk(ra[0] == da, "R1 descriptor address", ra[0], da);
            chk(ra[1] == da + 32'd4, "R2 second word address", ra[1], da + 32'd4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({busy, done, fault, mem_rd_en} == 4'b0, "R10 reset state",
            {28'h0, busy, done, fault, mem_rd_en}, 32'h0);
        chk(lin_addr == 32'h0, "R10 reset address", lin_addr, 32'h0);
        @(negedge clk);
        for (int ti = 0; ti < 2; ti++)
            for (int idx = 0; idx < 16; idx++)
                for (int rp = 0; rp < 4; rp++)
                    for (int cp = 0; cp < 4; cp++)
                        for (int oi = 0; oi < 4; oi++) begin
                            logic [15:0] s;
                            logic [31:0] lim, off;
                            s   = {13'(idx), 1'(ti), 2'(rp)};
                            lim = {12'h0, d_lim(sel_daddr(s))};
                            off = (oi == 0) ? 32'h0 : (oi == 1) ? lim :
                                  (oi == 2) ? lim + 32'd1 : 32'hFFFF_FFFF;
                            run_req(s, off, 2'(cp));
                        end
        // highest index, local table (R1)
        run_req({13'h1FFF, 1'b1, 2'b00}, 32'h10, 2'd0);
        run_req({13'h1FFF, 1'b0, 2'b00}, 32'h0, 2'd0);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R11 single pulse", {31'h0, done}, 32'h0);
        chk(busy == 1'b0, "R10 idle after stream", {31'h0, busy}, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule